// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap Flag

This block is the integer execute stage of a small load/store processor. Each cycle it takes an operation code, two 32-bit register operands, a 16-bit immediate with a selector, and a 5-bit shift count. One clock later it presents a 32-bit result and a flag that requests an overflow exception.

The operations are:

- add and subtract, each in a plain form and in an overflow-checking form;
- bitwise AND, OR and XOR;
- load-high;
- six signed comparisons that write 0 or 1;
- clear and set;
- logical and arithmetic shifts, either by a register-supplied count or by the instruction's shift field.

The exception flag comes only from the checking add and subtract. The value written back is always the wrapped two's-complement result, so the trap logic decides whether that value is committed.

Operand B is chosen before it reaches any function unit. It is either the second register operand or the immediate sign-extended to 32 bits. Every two-operand operation therefore has a register form and an immediate form through the same selector.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q` and `ovf_q` become 0 at that edge.
- R2: The outputs are registered. Inputs sampled at a rising edge with `rst` low determine `res_q` and `ovf_q` right after that edge.
- R3: The selected operand B is `{{16{imm[15]}}, imm}` when `imm_sel` is 1 and `opnd_b` when it is 0. This applies to every operation that uses B, logic operations included.
- R4: Code 0 (add) and code 2 (subtract) give `opnd_a + B` and `opnd_a - B` modulo 2^32. They never raise `ovf_q`.
- R5: Code 1 (checking add) gives the same wrapped sum. It raises `ovf_q` exactly when A and B have equal sign bits and the sum's sign bit differs from them.
- R6: Code 3 (checking subtract) gives the same wrapped difference. It raises `ovf_q` exactly when the signs of A and B differ and the difference's sign bit equals B's sign bit.
- R7: `ovf_q` is 1 only for codes 1 and 3.
- R8: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B.
- R9: Code 7 (load-high) gives `{B[15:0], 16'h0000}`.
- R10: Codes 10 through 15 compare A and B as signed values: greater, equal, greater-or-equal, less, not-equal and less-or-equal, in that order. The result is exactly 0 or 1.
- R11: Code 8 gives 0 and code 9 gives 1.
- R12: Shift operations:
  - Codes 16, 17 and 18 shift A left, right-logical and right-arithmetic by `B[4:0]`; the upper bits of B have no effect.
  - Codes 19, 20 and 21 do the same by `shamt`.
  - Logical right shifts fill with 0. Arithmetic right shifts replicate bit 31.
- R13: Codes 22 to 31 are reserved and give a result of 0 with `ovf_q` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| imm_sel | input | 1 | 1 selects the sign-extended immediate as operand B |
| shamt | input | 5 | Shift count for the immediate-count shifts |
| res_q | output | 32 | Registered result |
| ovf_q | output | 1 | Registered overflow-exception request |

## Verification
The unit holds no state beyond its output register, so a wrong internal value shows up at `res_q` or `ovf_q` in the cycle right after the operation that caused it. Nothing carries into later cycles.

The risky parts sit at boundaries, so the directed cases target them:

- the most negative and most positive operands in checking add and subtract, where a swapped sign term in the overflow rule shows as a missing or spurious flag;
- compares across the sign boundary, where an unsigned comparison gives the opposite answer;
- arithmetic shifts of negative values by 31;
- register-count shifts whose upper count bits are set, which must be ignored.

Random traffic over every code, including the reserved ones, is checked against a behavioural model on every clock.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int XLEN  = 32;
  localparam int IMMW  = 16;
  localparam int OPW   = 5;

  typedef enum logic [OPW-1:0] {
    EX_ADD  = 5'd0,  EX_ADDV = 5'd1,  EX_SUB  = 5'd2,  EX_SUBV = 5'd3,
    EX_AND  = 5'd4,  EX_OR   = 5'd5,  EX_XOR  = 5'd6,  EX_LDHI = 5'd7,
    EX_CLR  = 5'd8,  EX_SET  = 5'd9,  EX_CGT  = 5'd10, EX_CEQ  = 5'd11,
    EX_CGE  = 5'd12, EX_CLT  = 5'd13, EX_CNE  = 5'd14, EX_CLE  = 5'd15,
    EX_SLLV = 5'd16, EX_SRLV = 5'd17, EX_SRAV = 5'd18,
    EX_SLLI = 5'd19, EX_SRLI = 5'd20, EX_SRAI = 5'd21
  } ex_op_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARITH} sh_kind_e;
endpackage

// File: rtl/ex_addsub.sv
module ex_addsub #(
  parameter int W = 32
) (
  input  logic         subtract,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sgn_ovf
);
  localparam int MSB = W - 1;

  always_comb begin
    if (subtract) begin
      sum     = a - b;
      sgn_ovf = (a[MSB] != b[MSB]) && (sum[MSB] == b[MSB]);
    end else begin
      sum     = a + b;
      sgn_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
  end
endmodule

// File: rtl/ex_compare.sv
module ex_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         eq,
  output logic         lt
);
  always_comb begin
    eq = (a == b);
    lt = ($signed(a) < $signed(b));
    gt = !eq && !lt;
  end
endmodule

// File: rtl/ex_shifter.sv
module ex_shifter
  import int_exec_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  sh_kind_e       kind,
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (kind)
      SH_LEFT:   y = a << amt;
      SH_RARITH: y = W'($signed(a) >>> amt);
      default:   y = a >> amt;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_W  = IMMW,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              imm_sel,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res_q,
  output logic              ovf_q
);
  localparam int HALF = DATA_W / 2;

  ex_op_e        opc;
  logic [DATA_W-1:0] b_sel, as_sum, sh_y, res_d;
  logic          as_ovf, c_gt, c_eq, c_lt, ovf_d, is_sub;
  sh_kind_e      sh_kind;
  logic [SH_W-1:0] sh_amt;

  assign opc   = ex_op_e'(op);
  assign b_sel = imm_sel ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : opnd_b;
  assign is_sub = (opc == EX_SUB) || (opc == EX_SUBV);

  ex_addsub #(.W(DATA_W)) u_addsub (
    .subtract(is_sub), .a(opnd_a), .b(b_sel), .sum(as_sum), .sgn_ovf(as_ovf)
  );

  ex_compare #(.W(DATA_W)) u_cmp (
    .a(opnd_a), .b(b_sel), .gt(c_gt), .eq(c_eq), .lt(c_lt)
  );

  always_comb begin
    unique case (opc)
      EX_SLLV, EX_SLLI: sh_kind = SH_LEFT;
      EX_SRAV, EX_SRAI: sh_kind = SH_RARITH;
      default:          sh_kind = SH_RLOG;
    endcase
    sh_amt = (opc == EX_SLLI || opc == EX_SRLI || opc == EX_SRAI) ? shamt : b_sel[SH_W-1:0];
  end

  ex_shifter #(.W(DATA_W), .SHW(SH_W)) u_shift (
    .kind(sh_kind), .a(opnd_a), .amt(sh_amt), .y(sh_y)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    case (opc)
      EX_ADD, EX_SUB:   res_d = as_sum;
      EX_ADDV, EX_SUBV: begin res_d = as_sum; ovf_d = as_ovf; end
      EX_AND:  res_d = opnd_a & b_sel;
      EX_OR:   res_d = opnd_a | b_sel;
      EX_XOR:  res_d = opnd_a ^ b_sel;
      EX_LDHI: res_d = {b_sel[HALF-1:0], {HALF{1'b0}}};
      EX_CLR:  res_d = '0;
      EX_SET:  res_d = DATA_W'(1);
      EX_CGT:  res_d = DATA_W'(c_gt);
      EX_CEQ:  res_d = DATA_W'(c_eq);
      EX_CGE:  res_d = DATA_W'(c_gt | c_eq);
      EX_CLT:  res_d = DATA_W'(c_lt);
      EX_CNE:  res_d = DATA_W'(!c_eq);
      EX_CLE:  res_d = DATA_W'(c_lt | c_eq);
      EX_SLLV, EX_SRLV, EX_SRAV,
      EX_SLLI, EX_SRLI, EX_SRAI: res_d = sh_y;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (res_q == '0 && !ovf_q));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> ($past(op) == OPW'(EX_ADDV) || $past(op) == OPW'(EX_SUBV)));

  // R10
  cmp_boolean_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op) >= OPW'(EX_CGT) && $past(op) <= OPW'(EX_CLE)) |-> (res_q[DATA_W-1:1] == '0));

  // R9
  ldhi_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op) == OPW'(EX_LDHI)) |-> (res_q[HALF-1:0] == '0));

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op) == OPW'(EX_CLR)) |-> (res_q == '0));

  // R13
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op) > OPW'(EX_SRAI)) |-> (res_q == '0 && !ovf_q));
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  import int_exec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm = '0;
  logic        imm_sel = 1'b0;
  logic [4:0]  shamt = '0;
  logic [31:0] res_q;
  logic        ovf_q;

  int checks = 0, errors = 0;
  bit have_exp = 0;
  logic [31:0] exp_res;
  logic        exp_ovf;
  string       exp_tag;

  always #4 clk = ~clk;

  int_exec_unit uut (
    .clk(clk), .rst(rst), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm(imm), .imm_sel(imm_sel), .shamt(shamt), .res_q(res_q), .ovf_q(ovf_q)
  );

  function automatic string tag_of(int code);
    if (code == 0 || code == 2) return "R4";
    if (code == 1) return "R5";
    if (code == 3) return "R6";
    if (code >= 4 && code <= 6) return "R8";
    if (code == 7) return "R9";
    if (code == 8 || code == 9) return "R11";
    if (code >= 10 && code <= 15) return "R10";
    if (code >= 16 && code <= 21) return "R12";
    return "R13";
  endfunction

  task automatic model(input int code, input logic [31:0] a, input logic [31:0] b,
                       input int sh, output logic [31:0] r, output logic v);
    longint sa, sb, wide;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = 0; v = 0;
    case (code)
      0, 1: begin wide = sa + sb; r = wide[31:0]; if (code == 1) v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      2, 3: begin wide = sa - sb; r = wide[31:0]; if (code == 3) v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = b * 32'd65536;
      8: r = 0;
      9: r = 1;
      10: r = (sa >  sb) ? 1 : 0;
      11: r = (sa == sb) ? 1 : 0;
      12: r = (sa >= sb) ? 1 : 0;
      13: r = (sa <  sb) ? 1 : 0;
      14: r = (sa != sb) ? 1 : 0;
      15: r = (sa <= sb) ? 1 : 0;
      16, 19: begin int n; n = (code == 16) ? int'(b % 32) : sh; r = a; for (int i = 0; i < n; i++) r = r * 2; end
      17, 20: begin int n; n = (code == 17) ? int'(b % 32) : sh; r = a; for (int i = 0; i < n; i++) r = r / 2; end
      18, 21: begin int n; n = (code == 18) ? int'(b % 32) : sh; r = a; for (int i = 0; i < n; i++) r = {r[31], r[31:1]}; end
      default: r = 0;
    endcase
  endtask

  task automatic compare_now();
    checks++;
    if (res_q !== exp_res || ovf_q !== exp_ovf) begin
      errors++;
      $display("FAIL %s (R2): res=%h ovf=%b expected res=%h ovf=%b", exp_tag, res_q, ovf_q, exp_res, exp_ovf);
    end
  endtask

  task automatic step(input int code, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic isel, input int sh);
    logic [31:0] bsel;
    @(negedge clk);
    if (have_exp) compare_now();
    op = code[4:0]; opnd_a = a; opnd_b = b; imm = im; imm_sel = isel; shamt = sh[4:0];
    rst = 1'b0;
    // R3: immediate is sign-extended into operand B
    bsel = isel ? {{16{im[15]}}, im} : b;
    model(code, a, bsel, sh, exp_res, exp_ovf);
    exp_tag = isel ? {tag_of(code), "/R3"} : tag_of(code);
    have_exp = 1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    op = 5'd9; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1234_5678;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (res_q !== 32'h0 || ovf_q !== 1'b0) begin
        errors++;
        $display("FAIL R1: res=%h ovf=%b expected res=0 ovf=0", res_q, ovf_q);
      end
    end
    // R5 add overflow boundaries
    step(1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
    step(1, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 32'h7FFF_FFFE, 32'h1, 0, 0, 0);
    step(1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0);
    // R4 plain forms never flag
    step(0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
    step(2, 32'h8000_0000, 32'h1, 0, 0, 0);
    // R6 subtract overflow boundaries
    step(3, 32'h8000_0000, 32'h1, 0, 0, 0);
    step(3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    step(3, 32'h0, 32'h8000_0000, 0, 0, 0);
    step(3, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0);
    // R3 immediate forms
    step(1, 32'h7FFF_FFFF, 0, 16'h0001, 1, 0);
    step(0, 32'h10, 32'hDEAD, 16'hFFFF, 1, 0);
    step(4, 32'hFFFF_FFFF, 0, 16'h8001, 1, 0);
    // R9 load-high
    step(7, 0, 32'hABCD_1234, 0, 0, 0);
    step(7, 0, 0, 16'hBEEF, 1, 0);
    // R10 signed compares across sign boundary
    for (int c = 10; c <= 15; c++) begin
      step(c, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
      step(c, 32'h5, 32'h5, 0, 0, 0);
      step(c, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0);
    end
    // R11
    step(8, 32'h1234, 32'h5678, 0, 0, 0);
    step(9, 32'h1234, 32'h5678, 0, 0, 0);
    // R12 shifts, upper count bits ignored
    step(18, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0);
    step(17, 32'h8000_0000, 32'h0000_0FFF, 0, 0, 0);
    step(16, 32'h0000_0003, 32'hFFFF_FFE1, 0, 0, 0);
    step(21, 32'h8765_4321, 0, 0, 0, 31);
    step(20, 32'h8765_4321, 0, 0, 0, 4);
    step(19, 32'h8765_4321, 0, 0, 0, 0);
    // R13 reserved codes
    for (int c = 22; c <= 31; c++) step(c, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 0, 3);
    // random over all codes
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 31), $urandom, $urandom, 16'($urandom), 1'($urandom), $urandom_range(0, 31));
    @(negedge clk);
    compare_now();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule